// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit logical address into a physical address. It walks a tree of translation tables held in memory. The walk begins at a root pointer word supplied on a port. A field cut from the logical address indexes each table level. The walker reads one 32-bit descriptor per level through a memory port that allows one access at a time. At the end of a walk it reports the physical address, the write-protect state merged along the path, and a fault code.

A page descriptor may appear at any level and stops the walk there. In the root pointer it maps the whole space. In the first-level table it maps a contiguous block, and the unused logical bits become the offset into that block. A table descriptor carries a limit on the index into the table below it. Every valid descriptor read from memory whose used bit is clear is written back with that bit set, before the walk goes on.

A request is launched with a one-cycle `start` pulse. `busy` stays high while the walk runs. A one-cycle `done` pulse marks the cycle in which the results are valid.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req_valid` are low. No memory request is raised while the walker is idle.
- R2: If the root pointer is a page descriptor (type bits [1:0] = 01), the walk ends with no memory access. `phys_addr` equals the logical address, `done` rises one cycle after `start` is taken, and the fault code is 0 (none).
- R3: For a table descriptor (type 10), the next table starts at base `{desc[31:16],16'h0}`. The descriptor address is that base plus 4 times the index. The root uses index A = logical bits [31:20]; a first-level descriptor uses index B = logical bits [19:10]. A request is held, with a stable address, until `mem_req_ready`.
- R4: A page descriptor found in the page table gives `phys_addr = {desc[31:10], logical[9:0]}`.
- R5: A page descriptor found in the first-level table ends the walk early with `phys_addr = {desc[31:20], logical[19:0]}`.
- R6: If the index for the next table is greater than the parent table descriptor's limit field desc[15:4], the walk ends with fault code 2 (limit). The table below is not read.
- R7: Type 00 or 11 at any level, or a table descriptor found in the page table, ends the walk with fault code 1 (invalid). On every fault, `phys_addr` is 0.
- R8: Bit 2 (write protect) is ORed over every descriptor visited, the root included, and reported on `wp_out`. A write access whose merged bit is set ends with fault code 3 (protection). A read access with the same path translates normally.
- R9: When a valid descriptor read from memory has bit 3 (used) clear, the walker writes the same word back with bit 3 set, to the same address, before it continues. No write is issued when the bit is already set.
- R10: `done` is a single-cycle pulse and `busy` is low in that cycle. The `start` input is ignored while `busy` is high. A walk takes 1 cycle, plus 3 per descriptor read, plus 1 per used-bit write-back (the memory answers one cycle after the request is taken).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a walk (taken when idle) |
| va | input | 32 | Logical address to translate |
| is_write | input | 1 | Access is a write |
| root_ptr | input | 32 | Root pointer descriptor |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| phys_addr | output | 32 | Translated address (0 on fault) |
| wp_out | output | 1 | Merged write-protect bit |
| fault | output | 2 | 0 none, 1 invalid, 2 limit, 3 protection |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Request is a write-back |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write-back data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
After `start` is accepted, `done` is due exactly 1 + 3·reads + write-backs cycles later. `busy` is due high in every cycle before that. The bench derives this count from its own behavioural walk of the memory image. On every clock of the walk, it compares `busy` and `done` against that count. At the predicted cycle it samples `phys_addr`, `wp_out` and `fault`, and it then compares the write-backs it recorded against the list it predicted.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int DESC_W    = 32;
  localparam int WP_BIT    = 2;
  localparam int USED_BIT  = 3;
  localparam int LIM_LSB   = 4;
  localparam int LIM_W     = 12;
  localparam int TBASE_LSB = 16;

  typedef enum logic [1:0] {
    DT_INVALID = 2'b00,
    DT_PAGE    = 2'b01,
    DT_TABLE   = 2'b10,
    DT_RSVD    = 2'b11
  } dtype_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_LIMIT   = 2'd2,
    FLT_PROT    = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WB_REQ
  } wstate_e;

  // base of the table a table descriptor points to
  function automatic logic [DESC_W-1:0] table_base(input logic [DESC_W-1:0] d);
    return {d[DESC_W-1:TBASE_LSB], {TBASE_LSB{1'b0}}};
  endfunction

  // word-aligned entry address inside a table
  function automatic logic [DESC_W-1:0] entry_addr(input logic [DESC_W-1:0] base,
                                                   input logic [LIM_W-1:0]  idx);
    return base + DESC_W'({idx, 2'b00});
  endfunction

  // block base from the descriptor, offset from the logical address
  function automatic logic [DESC_W-1:0] block_phys(input logic [DESC_W-1:0] d,
                                                   input logic [DESC_W-1:0] la,
                                                   input logic [DESC_W-1:0] mask);
    return (d & ~mask) | (la & mask);
  endfunction

  function automatic logic desc_is_valid(input logic [DESC_W-1:0] d);
    return (d[1:0] == DT_PAGE) || (d[1:0] == DT_TABLE);
  endfunction

endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel
  import ptw_pkg::*;
#(
  parameter int A_W  = 12,
  parameter int PG_W = 10,
  localparam int B_W = DESC_W - A_W - PG_W,
  localparam int HI_W = DESC_W - PG_W
) (
  input  logic [HI_W-1:0]  la_hi,
  input  logic [1:0]       level,
  output logic [LIM_W-1:0] idx
);
  logic [A_W-1:0] a_field;
  logic [B_W-1:0] b_field;

  assign a_field = la_hi[HI_W-1 -: A_W];
  assign b_field = la_hi[B_W-1:0];

  always_comb begin
    if (level == 2'd0) idx = LIM_W'(a_field);
    else               idx = LIM_W'(b_field);
  end
endmodule

// File: rtl/ptw_desc_eval.sv
module ptw_desc_eval
  import ptw_pkg::*;
#(
  parameter int A_W  = 12,
  parameter int PG_W = 10,
  localparam int HI_W = DESC_W - PG_W,
  localparam logic [DESC_W-1:0] MASK_L0 = '1,
  localparam logic [DESC_W-1:0] MASK_L1 = (DESC_W'(1) << (DESC_W - A_W)) - DESC_W'(1),
  localparam logic [DESC_W-1:0] MASK_L2 = (DESC_W'(1) << PG_W) - DESC_W'(1)
) (
  input  logic [DESC_W-1:0] desc,
  input  logic [1:0]        level,
  input  logic [DESC_W-1:0] la,
  input  logic              is_write,
  input  logic              wp_in,
  output logic              ev_term,
  output fault_e            ev_fault,
  output logic [DESC_W-1:0] ev_phys,
  output logic              ev_wp,
  output logic [DESC_W-1:0] ev_next_addr,
  output logic              ev_limit_hit
);
  logic [LIM_W-1:0]  idx;
  logic [LIM_W-1:0]  limit;
  logic [DESC_W-1:0] blk_mask;

  ptw_index_sel #(.A_W(A_W), .PG_W(PG_W)) idx_sel_i (
    .la_hi (la[DESC_W-1:PG_W]),
    .level (level),
    .idx   (idx)
  );

  assign limit = desc[LIM_LSB +: LIM_W];
  assign ev_wp = wp_in | desc[WP_BIT];

  always_comb begin
    case (level)
      2'd0:    blk_mask = MASK_L0;
      2'd1:    blk_mask = MASK_L1;
      default: blk_mask = MASK_L2;
    endcase
  end

  always_comb begin
    ev_term      = 1'b0;
    ev_fault     = FLT_NONE;
    ev_phys      = '0;
    ev_limit_hit = 1'b0;
    ev_next_addr = entry_addr(table_base(desc), idx);
    case (desc[1:0])
      DT_PAGE: begin
        ev_term = 1'b1;
        if (is_write && ev_wp) ev_fault = FLT_PROT;
        else                   ev_phys  = block_phys(desc, la, blk_mask);
      end
      DT_TABLE: begin
        if (level == 2'd2) begin
          ev_term  = 1'b1;
          ev_fault = FLT_INVALID;
        end else if (idx > limit) begin
          ev_term      = 1'b1;
          ev_fault     = FLT_LIMIT;
          ev_limit_hit = 1'b1;
        end
      end
      default: begin
        ev_term  = 1'b1;
        ev_fault = FLT_INVALID;
      end
    endcase
  end

  // R7: a fault never carries a physical address
  always_comb begin
    if (ev_term && ev_fault != FLT_NONE)
      assert_fault_zero_phys_R7: assert (ev_phys == '0);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int A_W  = 12,
  parameter int PG_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] va,
  input  logic        is_write,
  input  logic [31:0] root_ptr,
  output logic        busy,
  output logic        done,
  output logic [31:0] phys_addr,
  output logic        wp_out,
  output logic [1:0]  fault,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  wstate_e           state;
  logic [1:0]        level;
  logic [DESC_W-1:0] cur_desc;
  logic [DESC_W-1:0] va_q;
  logic              wr_q;
  logic              wp_acc;
  logic [DESC_W-1:0] addr_q;
  logic [DESC_W-1:0] wdata_q;

  logic              ev_term;
  fault_e            ev_fault;
  logic [DESC_W-1:0] ev_phys;
  logic              ev_wp;
  logic [DESC_W-1:0] ev_next_addr;
  logic              ev_limit_hit;

  // named internal events
  logic ev_accept, ev_rd_fire, ev_wb_fire, ev_rsp, ev_need_wb;

  ptw_desc_eval #(.A_W(A_W), .PG_W(PG_W)) eval_i (
    .desc         (cur_desc),
    .level        (level),
    .la           (va_q),
    .is_write     (wr_q),
    .wp_in        (wp_acc),
    .ev_term      (ev_term),
    .ev_fault     (ev_fault),
    .ev_phys      (ev_phys),
    .ev_wp        (ev_wp),
    .ev_next_addr (ev_next_addr),
    .ev_limit_hit (ev_limit_hit)
  );

  assign ev_accept  = start && (state == ST_IDLE);
  assign ev_rd_fire = (state == ST_RD_REQ) && mem_req_ready;
  assign ev_wb_fire = (state == ST_WB_REQ) && mem_req_ready;
  assign ev_rsp     = (state == ST_RD_WAIT) && mem_rvalid;
  assign ev_need_wb = desc_is_valid(mem_rdata) && !mem_rdata[USED_BIT];

  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WB_REQ);
  assign mem_we        = (state == ST_WB_REQ);
  assign mem_addr      = addr_q;
  assign mem_wdata     = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      level     <= 2'd0;
      cur_desc  <= '0;
      va_q      <= '0;
      wr_q      <= 1'b0;
      wp_acc    <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      done      <= 1'b0;
      phys_addr <= '0;
      wp_out    <= 1'b0;
      fault     <= FLT_NONE;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ev_accept) begin
            cur_desc <= root_ptr;
            va_q     <= va;
            wr_q     <= is_write;
            wp_acc   <= 1'b0;
            level    <= 2'd0;
            state    <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          wp_acc <= ev_wp;
          if (ev_term) begin
            done      <= 1'b1;
            phys_addr <= ev_phys;
            wp_out    <= ev_wp;
            fault     <= ev_fault;
            state     <= ST_IDLE;
          end else begin
            addr_q <= ev_next_addr;
            level  <= level + 2'd1;
            state  <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: begin
          if (ev_rd_fire) state <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (ev_rsp) begin
            cur_desc <= mem_rdata;
            if (ev_need_wb) begin
              wdata_q <= mem_rdata | (DESC_W'(1) << USED_BIT);
              state   <= ST_WB_REQ;
            end else begin
              state <= ST_EVAL;
            end
          end
        end
        ST_WB_REQ: begin
          if (ev_wb_fire) state <= ST_EVAL;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr) && $stable(mem_we)));

  assert_limit_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EVAL && ev_limit_hit) |=> (done && fault == FLT_LIMIT && !mem_req_valid));

  assert_prot_has_wp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == FLT_PROT) |-> wp_out);

  assert_wb_after_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid && mem_we) |-> ($past(mem_rvalid) && mem_wdata[USED_BIT]));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] va = '0;
  logic        is_write = 1'b0;
  logic [31:0] root_ptr = '0;
  logic        busy, done, wp_out, mem_req_valid, mem_we;
  logic [31:0] phys_addr, mem_addr, mem_wdata;
  logic [1:0]  fault;
  logic        mem_req_ready = 1'b1;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_wa[$], exp_wd[$], got_wa[$], got_wd[$];
  logic        rd_pend = 1'b0;
  logic [31:0] rd_addr = '0;

  always #10 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va), .is_write(is_write),
    .root_ptr(root_ptr), .busy(busy), .done(done), .phys_addr(phys_addr),
    .wp_out(wp_out), .fault(fault), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // memory responder: answers a read one cycle after acceptance
  always @(negedge clk) begin
    mem_rvalid <= 1'b0;
    if (rd_pend) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= rd(rd_addr);
      rd_pend    <= 1'b0;
    end
    if (mem_req_valid && mem_req_ready) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        got_wa.push_back(mem_addr);
        got_wd.push_back(mem_wdata);
      end else begin
        rd_pend <= 1'b1;
        rd_addr <= mem_addr;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural walk of the memory image
  task automatic model(input logic [31:0] la, input logic wr, input logic [31:0] root,
                       output logic [31:0] ephys, output logic ewp, output logic [1:0] eflt,
                       output int elat);
    logic [31:0] d, a, nd, mask;
    int lvl, idx, lim, span;
    d = root; lvl = 0; ewp = 1'b0; elat = 1; ephys = 0; eflt = 0;
    exp_wa.delete(); exp_wd.delete();
    forever begin
      ewp = ewp | d[2];
      if (d[1:0] == 2'b01) begin
        span = (lvl == 0) ? 32 : (lvl == 1) ? 20 : 10;
        mask = (span == 32) ? 32'hFFFF_FFFF : ((32'h1 << span) - 1);
        if (wr && ewp) eflt = 2'd3;
        else ephys = (d & ~mask) | (la & mask);
        break;
      end else if (d[1:0] == 2'b10 && lvl < 2) begin
        idx = (lvl == 0) ? int'(la >> 20) : int'((la >> 10) & 32'h3FF);
        lim = int'((d >> 4) & 32'hFFF);
        if (idx > lim) begin eflt = 2'd2; break; end
        a = {d[31:16], 16'h0} + 32'(idx * 4);
        nd = rd(a);
        elat = elat + 3;
        if ((nd[1:0] == 2'b01 || nd[1:0] == 2'b10) && !nd[3]) begin
          exp_wa.push_back(a);
          exp_wd.push_back(nd | 32'h8);
          elat = elat + 1;
        end
        d = nd; lvl = lvl + 1;
      end else begin
        eflt = 2'd1; break;
      end
    end
  endtask

  task automatic walk(input string tag, input logic [31:0] la, input logic wr,
                      input logic [31:0] root, input logic intrude);
    logic [31:0] ephys, gphys;
    logic ewp, gwp, tbad, seen;
    logic [1:0] eflt, gflt;
    int lat;
    model(la, wr, root, ephys, ewp, eflt, lat);
    got_wa.delete(); got_wd.delete();
    @(negedge clk);
    start = 1'b1; va = la; is_write = wr; root_ptr = root;
    @(negedge clk);
    start = 1'b0;
    tbad = 1'b0; seen = 1'b0; gphys = 0; gwp = 0; gflt = 0;
    for (int n = 1; n <= lat + 3; n++) begin
      if (intrude && n == 2) begin start = 1'b1; va = 32'hFFFF_FFFF; is_write = 1'b1; root_ptr = 32'h0; end
      if (intrude && n == 3) begin start = 1'b0; va = la; end
      @(negedge clk);
      if (busy !== (n < lat) || done !== (n == lat)) tbad = 1'b1;
      if (done) begin seen = 1'b1; gphys = phys_addr; gwp = wp_out; gflt = fault; end
    end
    // R10 latency and handshake
    check(!tbad && seen, {tag, " R10 busy/done timing"}, 32'(tbad), 32'(lat));
    check(gphys === ephys, {tag, " phys_addr"}, gphys, ephys);
    check(gwp === ewp, {tag, " R8 wp_out"}, 32'(gwp), 32'(ewp));
    check(gflt === eflt, {tag, " fault"}, 32'(gflt), 32'(eflt));
    // R9 write-back list
    check(got_wa.size() == exp_wa.size(), {tag, " R9 write-back count"},
          32'(got_wa.size()), 32'(exp_wa.size()));
    for (int i = 0; i < got_wa.size() && i < exp_wa.size(); i++) begin
      check(got_wa[i] === exp_wa[i] && got_wd[i] === exp_wd[i], {tag, " R9 write-back word"},
            got_wd[i], exp_wd[i]);
    end
  endtask

  localparam logic [31:0] ROOT = 32'h0001_FFF2;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && done === 1'b0 && mem_req_valid === 1'b0, "R1 reset outputs",
          {29'b0, busy, done, mem_req_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_req_valid === 1'b0 && busy === 1'b0, "R1 idle no request", 32'(mem_req_valid), 32'h0);

    mem[32'h0001_0028] = 32'h0002_3FF2;  // A=0x00A table, used clear
    mem[32'h0002_0018] = 32'h1234_5401;  // page, used clear
    mem[32'h0001_002C] = 32'hABC0_0001;  // A=0x00B early page
    mem[32'h0001_0030] = 32'h0003_0052;  // A=0x00C table, limit 5
    mem[32'h0001_0034] = 32'h0004_3FFA;  // A=0x00D table, used set
    mem[32'h0004_0000] = 32'h0000_0003;  // reserved type
    mem[32'h0004_0004] = 32'h0005_3FF2;  // table at page level
    mem[32'h0001_0038] = 32'h0006_3FFE;  // A=0x00E table with write protect
    mem[32'h0006_0000] = 32'h7770_0009;  // page, used set

    walk("R2 root page",            32'h1234_5678, 1'b0, 32'h0000_0001, 1'b0);
    walk("R3 R4 two-level",         32'h00A0_1B37, 1'b0, ROOT, 1'b0);
    check(rd(32'h0002_0018) === 32'h1234_5409, "R9 page used bit in memory",
          rd(32'h0002_0018), 32'h1234_5409);
    walk("R9 R10 rewalk, start ignored", 32'h00A0_1B37, 1'b1, ROOT, 1'b1);
    walk("R5 early block",          32'h00B5_4321, 1'b0, ROOT, 1'b0);
    walk("R6 root limit",           32'h00B0_0000, 1'b0, 32'h0001_00A2, 1'b0);
    walk("R6 table limit",          32'h00C0_1800, 1'b0, ROOT, 1'b0);
    walk("R6 table at limit",       32'h00C0_1400, 1'b0, ROOT, 1'b0);
    walk("R7 root invalid",         32'h0000_1000, 1'b0, 32'h0001_FFF0, 1'b0);
    walk("R7 root reserved",        32'h0000_1000, 1'b0, 32'h0001_FFF3, 1'b0);
    walk("R7 reserved in page tbl", 32'h00D0_0000, 1'b0, ROOT, 1'b0);
    walk("R7 table in page tbl",    32'h00D0_0400, 1'b0, ROOT, 1'b0);
    walk("R8 wp read",              32'h00E0_0123, 1'b0, ROOT, 1'b0);
    walk("R8 wp write",             32'h00E0_0123, 1'b1, ROOT, 1'b0);
    walk("R8 root wp write",        32'h5555_0000, 1'b1, 32'h0000_0005, 1'b0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule